// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This combinational block decides whether a short conditional branch is taken and produces the address of the next instruction. A 4-bit selector picks one of fourteen conditions. The condition is tested against the four arithmetic flags: zero, negative, carry and overflow. Signed orderings use the negative and overflow flags together. Unsigned orderings use carry and zero. The remaining codes test a single flag, or branch always.

The branch address, the instruction length in bytes and a signed 8-bit displacement are also inputs. A taken branch goes to the branch's own address plus the sign-extended displacement, not to an address relative to the following instruction. A branch that is not taken falls through to the branch address plus its length. The block has no state. It sits between instruction decode and the fetch redirect logic.

Top module: `bcc_eval`

## Requirements
- R1: Signed conditions. Selector 0 (less) is taken when N differs from V. Selector 1 (greater) is taken when Z is clear and N equals V. Selector 2 (greater-or-equal) is taken when N equals V. Selector 3 (less-or-equal) is taken when Z is set or N differs from V.
- R2: Unsigned conditions. Selector 5 (higher) is taken when both C and Z are clear. Selector 7 (lower-or-same) is taken when C or Z is set.
- R3: Selector 8 is taken when Z is set. Selector 9 is taken when Z is clear.
- R4: Single-flag conditions. Selector 4 is taken when C is set and selector 6 when C is clear. Selector 12 is taken when V is set and selector 11 when V is clear. Selector 13 is taken when N is set.
- R5: Selector 10 is taken for every flag combination.
- R6: Selectors 14 and 15 are never taken, whatever the flags.
- R7: When taken, next_pc equals pc_in plus the 8-bit displacement sign-extended to the PC width. Displacement 0x80 therefore moves back by 128.
- R8: When not taken, next_pc equals pc_in plus insn_len taken as an unsigned byte count.
- R9: Both the target and the fall-through sum wrap modulo 2^PC_W.
- R10: When the branch is taken, insn_len has no effect on next_pc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_sel | input | 4 | Condition selector code |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| pc_in | input | PC_W (32) | Address of the branch instruction |
| insn_len | input | LEN_W (2) | Branch length in bytes (2 or 3) |
| disp | input | DISP_W (8) | Signed displacement |
| br_taken | output | 1 | Branch condition holds |
| next_pc | output | PC_W (32) | Address of the next instruction |

## Verification
Condition evaluation and target arithmetic act in the same evaluation. Their results meet at the next_pc select. A fault in either one can be hidden by the other when the displacement equals the length, because then both paths give the same address. The bench therefore judges br_taken separately from next_pc. It steers displacements away from the length in the directed sweep. It also aims corner cases at PC wrap in both directions and on both the taken and the fall-through path.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int SEL_W     = 4;
  localparam int NUM_CODES = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    CND_LT = 4'd0,  CND_GT = 4'd1,  CND_GE = 4'd2,  CND_LE = 4'd3,
    CND_CS = 4'd4,  CND_HI = 4'd5,  CND_CC = 4'd6,  CND_LS = 4'd7,
    CND_EQ = 4'd8,  CND_NE = 4'd9,  CND_RA = 4'd10, CND_VC = 4'd11,
    CND_VS = 4'd12, CND_NS = 4'd13, CND_X0 = 4'd14, CND_X1 = 4'd15
  } cond_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;

  // Evaluate one condition code against the flag set.
  function automatic logic cond_hit(input cond_e s, input flags_t f);
    logic sgn_lt;
    sgn_lt = f.n ^ f.v;
    case (s)
      CND_LT:  cond_hit = sgn_lt;
      CND_GT:  cond_hit = !f.z && !sgn_lt;
      CND_GE:  cond_hit = !sgn_lt;
      CND_LE:  cond_hit = f.z || sgn_lt;
      CND_CS:  cond_hit = f.c;
      CND_HI:  cond_hit = !f.c && !f.z;
      CND_CC:  cond_hit = !f.c;
      CND_LS:  cond_hit = f.c || f.z;
      CND_EQ:  cond_hit = f.z;
      CND_NE:  cond_hit = !f.z;
      CND_RA:  cond_hit = 1'b1;
      CND_VC:  cond_hit = !f.v;
      CND_VS:  cond_hit = f.v;
      CND_NS:  cond_hit = f.n;
      default: cond_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bcc_cond_decode.sv
module bcc_cond_decode
  import bcc_pkg::*;
(
  input  cond_e                sel,
  input  flags_t               flg,
  output logic [NUM_CODES-1:0] hit_vec,
  output logic                 hit
);
  // One evaluator per selector code; the selector then picks one.
  for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_code
    assign hit_vec[gi] = cond_hit(cond_e'(gi), flg);
  end

  assign hit = hit_vec[sel];

  // Complementary condition pairs must always disagree.
  always_comb begin
    if (!$isunknown(flg)) begin
      p_gt_le_pair_r1: assert (hit_vec[CND_GT] != hit_vec[CND_LE])
        else $error("GT/LE pair agree");
      p_ge_lt_pair_r1: assert (hit_vec[CND_GE] != hit_vec[CND_LT])
        else $error("GE/LT pair agree");
      p_hi_ls_pair_r2: assert (hit_vec[CND_HI] != hit_vec[CND_LS])
        else $error("HI/LS pair agree");
      p_eq_ne_pair_r3: assert (hit_vec[CND_EQ] != hit_vec[CND_NE])
        else $error("EQ/NE pair agree");
      p_carry_pair_r4: assert (hit_vec[CND_CS] != hit_vec[CND_CC])
        else $error("carry pair agree");
      p_ovf_pair_r4: assert (hit_vec[CND_VS] != hit_vec[CND_VC])
        else $error("overflow pair agree");
      p_always_r5: assert (hit_vec[CND_RA])
        else $error("always code not taken");
      p_unused_r6: assert (!hit_vec[CND_X0] && !hit_vec[CND_X1])
        else $error("unused code taken");
    end
  end
endmodule

// File: rtl/bcc_target_calc.sv
module bcc_target_calc #(
  parameter int PC_W   = 32,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic [PC_W-1:0]   pc_in,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [DISP_W-1:0] disp,
  input  logic              taken,
  output logic [PC_W-1:0]   tgt_pc,
  output logic [PC_W-1:0]   fall_pc,
  output logic [PC_W-1:0]   next_pc
);
  localparam int EXT_W = PC_W - DISP_W;
  localparam int PAD_W = PC_W - LEN_W;

  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] base,
                                                 input logic [DISP_W-1:0] d);
    rel_target = base + {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] base,
                                               input logic [LEN_W-1:0] l);
    seq_next = base + {{PAD_W{1'b0}}, l};
  endfunction

  assign tgt_pc  = rel_target(pc_in, disp);
  assign fall_pc = seq_next(pc_in, insn_len);
  assign next_pc = taken ? tgt_pc : fall_pc;

  // Offsets restated as differences, so that wrap is checked as well.
  always_comb begin
    if (!$isunknown({pc_in, insn_len, disp, taken})) begin
      if (taken) begin
        p_taken_offset_r7: assert ($signed(next_pc - pc_in) == $signed(disp))
          else $error("taken offset wrong");
      end else begin
        p_fall_offset_r8: assert ((next_pc - pc_in) == PC_W'(insn_len))
          else $error("fall-through offset wrong");
      end
    end
  end
endmodule

// File: rtl/bcc_eval.sv
module bcc_eval
  import bcc_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic [3:0]        cond_sel,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [LEN_W-1:0]  insn_len,
  input  logic [DISP_W-1:0] disp,
  output logic              br_taken,
  output logic [PC_W-1:0]   next_pc
);
  flags_t               flg;
  cond_e                sel;
  logic [NUM_CODES-1:0] hit_vec;
  logic                 cond_ok;
  logic [PC_W-1:0]      tgt_pc;
  logic [PC_W-1:0]      fall_pc;

  assign flg = '{z: flag_z, n: flag_n, c: flag_c, v: flag_v};
  assign sel = cond_e'(cond_sel);

  bcc_cond_decode u_dec (
    .sel     (sel),
    .flg     (flg),
    .hit_vec (hit_vec),
    .hit     (cond_ok)
  );

  bcc_target_calc #(.PC_W(PC_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_tgt (
    .pc_in    (pc_in),
    .insn_len (insn_len),
    .disp     (disp),
    .taken    (cond_ok),
    .tgt_pc   (tgt_pc),
    .fall_pc  (fall_pc),
    .next_pc  (next_pc)
  );

  assign br_taken = cond_ok;

  // Port-level checks tying the flags to the decision.
  always_comb begin
    if (!$isunknown({cond_sel, flag_z, flag_n, flag_c, flag_v})) begin
      if (sel == CND_GT && br_taken) begin
        p_gt_flags_r1: assert (!flag_z && (flag_n == flag_v))
          else $error("GT taken with wrong flags");
      end
      if (sel == CND_HI && br_taken) begin
        p_hi_flags_r2: assert (!flag_z && !flag_c)
          else $error("HI taken with wrong flags");
      end
      if (sel == CND_EQ) begin
        p_eq_flags_r3: assert (br_taken == flag_z)
          else $error("EQ mismatch");
      end
      if (sel == CND_RA) begin
        p_ra_taken_r5: assert (br_taken)
          else $error("always not taken");
      end
      if (cond_sel >= 4'd14) begin
        p_unused_port_r6: assert (!br_taken)
          else $error("unused code taken");
      end
    end
    if (!$isunknown({br_taken, tgt_pc, fall_pc})) begin
      if (br_taken) begin
        p_len_ignored_r10: assert (next_pc == tgt_pc)
          else $error("length leaked into target");
      end
    end
  end
endmodule

// File: tb/bcc_eval_bench.sv
module bcc_eval_bench;
  localparam int PCW = 32;

  logic        clk = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic        fz = 1'b0, fn = 1'b0, fc = 1'b0, fv = 1'b0;
  logic [31:0] pc_in = '0;
  logic [1:0]  insn_len = '0;
  logic [7:0]  disp = '0;
  logic        br_taken;
  logic [31:0] next_pc;
  int          total = 0;
  int          bad = 0;

  always #4 clk = ~clk;

  bcc_eval u_bcc_eval (
    .cond_sel (cond_sel), .flag_z (fz), .flag_n (fn), .flag_c (fc),
    .flag_v (fv), .pc_in (pc_in), .insn_len (insn_len), .disp (disp),
    .br_taken (br_taken), .next_pc (next_pc)
  );

  // Expected decision, written as a lookup on the selector.
  function automatic bit ref_taken(input logic [3:0] s, input bit z, n, c, v);
    bit less_s;
    less_s = (n != v);
    case (s)
      4'd0:  return less_s;
      4'd1:  return !(z || less_s);
      4'd2:  return !less_s;
      4'd3:  return !(!z && !less_s);
      4'd4:  return c;
      4'd5:  return !(c || z);
      4'd6:  return c == 1'b0;
      4'd7:  return !(!c && !z);
      4'd8:  return z;
      4'd9:  return z == 1'b0;
      4'd10: return 1'b1;
      4'd11: return v == 1'b0;
      4'd12: return v;
      4'd13: return n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    if (s <= 4'd3) return "R1";
    if (s == 4'd5 || s == 4'd7) return "R2";
    if (s == 4'd8 || s == 4'd9) return "R3";
    if (s == 4'd10) return "R5";
    if (s >= 4'd14) return "R6";
    return "R4";
  endfunction

  function automatic logic [31:0] ref_next(input bit tk, input logic [31:0] p,
                                           input logic [1:0] l, input logic [7:0] d);
    int signed off;
    off = tk ? int'($signed(d)) : int'(l);
    return p + 32'(off);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, input bit z, n, c, v,
                       input logic [31:0] p, input logic [1:0] l,
                       input logic [7:0] d, input string rq_pc);
    bit          et;
    logic [31:0] en;
    @(posedge clk);
    cond_sel = s; fz = z; fn = n; fc = c; fv = v;
    pc_in = p; insn_len = l; disp = d;
    @(negedge clk);
    et = ref_taken(s, z, n, c, v);
    en = ref_next(et, p, l, d);
    check(br_taken == et, req_of(s), {31'd0, br_taken}, {31'd0, et});
    check(next_pc == en, rq_pc, next_pc, en);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Idle state with all inputs low: selector 0 untaken, falls to pc+0.
    @(negedge clk);
    check(br_taken == 1'b0, "R1", {31'd0, br_taken}, 32'd0);
    check(next_pc == 32'd0, "R8", next_pc, 32'd0);

    // Exhaustive codes x flags; disp 0x40 kept away from the length.
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        apply(4'(s), f[3], f[2], f[1], f[0], 32'h0000_1000 + 32'(s * 64),
              (f[0] ? 2'd3 : 2'd2), 8'h40, "R7/R8 next_pc");
      end
    end

    // R7 negative displacement, R9 wrap on both paths.
    apply(4'd10, 0, 0, 0, 0, 32'h0000_0100, 2'd2, 8'h80, "R7 disp -128");
    apply(4'd10, 0, 0, 0, 0, 32'h0000_0001, 2'd2, 8'h80, "R9 wrap down");
    apply(4'd10, 0, 0, 0, 0, 32'hFFFF_FFF0, 2'd2, 8'h7F, "R9 wrap up");
    apply(4'd14, 0, 0, 0, 0, 32'hFFFF_FFFF, 2'd3, 8'h10, "R9 fall wrap");
    apply(4'd15, 1, 1, 1, 1, 32'hFFFF_FFFE, 2'd2, 8'h10, "R6 R8 fall");

    // R10: taken target identical for every length.
    for (int l = 0; l < 4; l++) begin
      apply(4'd10, 0, 0, 0, 0, 32'h0000_8000, 2'(l), 8'hF0, "R10 len ignored");
      check(next_pc == 32'h0000_7FF0, "R10", next_pc, 32'h0000_7FF0);
    end

    // Disp equal to length: both paths meet; the taken flag is still judged.
    apply(4'd8, 0, 0, 0, 0, 32'h0000_2000, 2'd2, 8'h02, "R3 R8 aliased");
    apply(4'd8, 1, 0, 0, 0, 32'h0000_2000, 2'd2, 8'h02, "R3 R7 aliased");

    // Seeded random stimulus.
    void'($urandom(32'h0BCC_5EED));
    for (int i = 0; i < 800; i++) begin
      logic [31:0] rr;
      rr = $urandom();
      apply(rr[3:0], rr[4], rr[5], rr[6], rr[7], $urandom(),
            (rr[8] ? 2'd3 : 2'd2), rr[23:16], "R7/R8/R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule